// File: doc/BRIEF.md
# Auto-Incrementing Register Access Port

This block connects a small command-processing microcontroller to an external register bus. The controller first loads a target register index. Each later data write sends one bus write to that index, and each read through the address alias sends one bus read. Both kinds of access advance the index by one, so runs of neighbouring registers can be written or read in a burst. When a bank flag is given with the index load, it ORs a bank bit into the index. Double-buffered registers use this bit to pick their second copy.

Three fixed indices form an indirect memory window. Two of them hold the low and high halves of a 64-bit memory pointer. These are stored inside the block and are not sent on the bus. The third index turns data writes and alias reads into memory-space bus accesses at the pointer, and the pointer then steps by one 32-bit word. A separate configuration-write command writes a register at an offset plus an immediate, and leaves the latched index alone. Each bus access uses a valid/ready handshake, and the controller is stalled until the access completes.

Top module: `ap_regport`

## Requirements
- R1: After reset, uc_ready is 1, bus_valid and uc_rvalid are 0, the register index is 0 and the memory pointer is 0.
- R2: Op code 0 (set index) latches uc_wdata[15:0] as the index, with bit 11 forced to 1 when uc_bank is 1. It causes no bus access and uc_ready stays 1.
- R3: Op code 1 (data write) at an ordinary index issues one register-space write (bus_mem=0, bus_write=1) of uc_wdata at the index, then increments the index.
- R4: Op code 2 (alias read) at an ordinary index issues one register-space read at the index. uc_rdata returns the bus_rdata of the completing handshake, with uc_rvalid high for one cycle, and the index increments.
- R5: The index is 16 bits wide and wraps from 0xFFFF to 0x0000.
- R6: At index 0x0530 (pointer low) and 0x0531 (pointer high), data writes load the matching 32-bit half of the memory pointer and alias reads return it on uc_rdata with uc_rvalid. There is no bus access, and the index increments.
- R7: At index 0x0532 (memory window), data writes and alias reads go to memory space (bus_mem=1) at the 64-bit pointer. The pointer then grows by 4 with full 64-bit carry, and the index stays unchanged.
- R8: Op code 3 (config write) writes uc_wdata to register (uc_offset + uc_imm) mod 2^16 and does not change the index.
- R9: bus_valid stays high, with address, data and direction stable, until bus_ready. uc_ready is low while a bus access is outstanding, and each accepted bus command gives exactly one handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uc_valid | input | 1 | Controller command valid |
| uc_ready | output | 1 | Command accepted when high together with uc_valid |
| uc_op | input | 2 | 0 set index, 1 data write, 2 alias read, 3 config write |
| uc_wdata | input | 32 | Write data or new index |
| uc_offset | input | 16 | Config-write base offset |
| uc_imm | input | 16 | Config-write immediate |
| uc_bank | input | 1 | Set bank bit on index load |
| uc_rvalid | output | 1 | Read data valid pulse |
| uc_rdata | output | 32 | Read data, held until the next read |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus request complete |
| bus_write | output | 1 | 1 write, 0 read |
| bus_mem | output | 1 | 1 memory space, 0 register space |
| bus_addr | output | 64 | Register index (zero-extended) or byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |

## Verification
The bench uses the default parameters: a 16-bit index, 32-bit data words, bank bit 11, the pointer pair at 0x0530/0x0531 with the memory window at 0x0532, and a 4-byte memory step. With a 16-bit index, the wrap from 0xFFFF needs only one index load and two accesses. With 32-bit halves, a low half of 0xFFFFFFFC shows the carry into the high half after one memory access. The pointer-window indices lie close enough together that random index loads near 0x0530 often step across them.

// File: rtl/ap_pkg.sv
package ap_pkg;

    typedef enum logic [1:0] {
        OP_SET_IDX  = 2'd0,
        OP_WR_DATA  = 2'd1,
        OP_RD_ALIAS = 2'd2,
        OP_CFG_WR   = 2'd3
    } ap_op_e;

    typedef enum logic [1:0] {
        WIN_REG    = 2'd0,
        WIN_PTR_LO = 2'd1,
        WIN_PTR_HI = 2'd2,
        WIN_MEM    = 2'd3
    } ap_win_e;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_WAIT = 1'b1
    } ap_bus_st_e;

    // Per-command control plan produced by the decoder
    typedef struct packed {
        logic bus_req;
        logic bus_wr;
        logic bus_mem;
        logic load_idx;
        logic adv_idx;
        logic adv_ptr;
        logic ld_lo;
        logic ld_hi;
        logic rd_lo;
        logic rd_hi;
    } ap_ctl_t;

    function automatic logic is_local_read(ap_ctl_t c);
        return c.rd_lo | c.rd_hi;
    endfunction

endpackage

// File: rtl/ap_decode.sv
module ap_decode
    import ap_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int DW = 32,
    parameter int BANK_BIT = 11,
    parameter logic [IDX_W-1:0] PTR_LO_IDX = 16'h0530
) (
    input  ap_op_e           op,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] offset,
    input  logic [IDX_W-1:0] imm,
    input  logic             bank,
    input  logic [IDX_W-1:0] cur_idx,
    output ap_ctl_t          ctl,
    output logic [IDX_W-1:0] reg_addr,
    output logic [IDX_W-1:0] new_idx
);

    localparam logic [IDX_W-1:0] PTR_HI_IDX = PTR_LO_IDX + IDX_W'(1);
    localparam logic [IDX_W-1:0] MEM_IDX    = PTR_LO_IDX + IDX_W'(2);

    logic [IDX_W-1:0] bank_mask;
    ap_win_e          win;

    generate
        if (BANK_BIT < IDX_W) begin : g_bank
            assign bank_mask = IDX_W'(1) << BANK_BIT;
        end else begin : g_nobank
            assign bank_mask = '0;
        end
    endgenerate

    always_comb begin
        if (cur_idx == PTR_LO_IDX)      win = WIN_PTR_LO;
        else if (cur_idx == PTR_HI_IDX) win = WIN_PTR_HI;
        else if (cur_idx == MEM_IDX)    win = WIN_MEM;
        else                            win = WIN_REG;
    end

    always_comb begin
        ctl      = '0;
        reg_addr = cur_idx;
        new_idx  = wdata[IDX_W-1:0] | (bank ? bank_mask : '0);
        unique case (op)
            OP_SET_IDX: ctl.load_idx = 1'b1;
            OP_WR_DATA: begin
                unique case (win)
                    WIN_PTR_LO: begin ctl.ld_lo = 1'b1; ctl.adv_idx = 1'b1; end
                    WIN_PTR_HI: begin ctl.ld_hi = 1'b1; ctl.adv_idx = 1'b1; end
                    WIN_MEM: begin
                        ctl.bus_req = 1'b1;
                        ctl.bus_wr  = 1'b1;
                        ctl.bus_mem = 1'b1;
                        ctl.adv_ptr = 1'b1;
                    end
                    default: begin
                        ctl.bus_req = 1'b1;
                        ctl.bus_wr  = 1'b1;
                        ctl.adv_idx = 1'b1;
                    end
                endcase
            end
            OP_RD_ALIAS: begin
                unique case (win)
                    WIN_PTR_LO: begin ctl.rd_lo = 1'b1; ctl.adv_idx = 1'b1; end
                    WIN_PTR_HI: begin ctl.rd_hi = 1'b1; ctl.adv_idx = 1'b1; end
                    WIN_MEM: begin
                        ctl.bus_req = 1'b1;
                        ctl.bus_mem = 1'b1;
                        ctl.adv_ptr = 1'b1;
                    end
                    default: begin
                        ctl.bus_req = 1'b1;
                        ctl.adv_idx = 1'b1;
                    end
                endcase
            end
            default: begin
                ctl.bus_req = 1'b1;
                ctl.bus_wr  = 1'b1;
                reg_addr    = offset + imm;
            end
        endcase
    end

endmodule

// File: rtl/ap_pointer.sv
module ap_pointer
    import ap_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int DW = 32,
    parameter int MEM_STEP = 4,
    localparam int MAW = 2 * DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  ap_ctl_t          ctl,
    input  logic [IDX_W-1:0] new_idx,
    input  logic [DW-1:0]    wdata,
    output logic [IDX_W-1:0] idx,
    output logic [MAW-1:0]   mptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (accept) begin
            if (ctl.load_idx)     idx <= new_idx;
            else if (ctl.adv_idx) idx <= idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mptr <= '0;
        end else if (accept) begin
            if (ctl.ld_lo)        mptr <= {mptr[MAW-1:DW], wdata};
            else if (ctl.ld_hi)   mptr <= {wdata, mptr[DW-1:0]};
            else if (ctl.adv_ptr) mptr <= mptr + MAW'(MEM_STEP);
        end
    end

endmodule

// File: rtl/ap_bus_port.sv
module ap_bus_port
    import ap_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          req_wr,
    input  logic          req_mem,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic          bus_write,
    output logic          bus_mem,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          rd_done
);

    ap_bus_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= BS_IDLE;
            bus_write <= 1'b0;
            bus_mem   <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            unique case (st)
                BS_IDLE: if (start) begin
                    st        <= BS_WAIT;
                    bus_write <= req_wr;
                    bus_mem   <= req_mem;
                    bus_addr  <= req_addr;
                    bus_wdata <= req_wdata;
                end
                default: if (bus_ready) st <= BS_IDLE;
            endcase
        end
    end

    assign bus_valid = (st == BS_WAIT);
    assign busy      = bus_valid;
    assign rd_done   = bus_valid && bus_ready && !bus_write;

endmodule

// File: rtl/ap_regport.sv
module ap_regport
    import ap_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int DW = 32,
    parameter int BANK_BIT = 11,
    parameter logic [IDX_W-1:0] PTR_LO_IDX = 16'h0530,
    parameter int MEM_STEP = 4,
    localparam int MAW = 2 * DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uc_valid,
    output logic             uc_ready,
    input  logic [1:0]       uc_op,
    input  logic [DW-1:0]    uc_wdata,
    input  logic [IDX_W-1:0] uc_offset,
    input  logic [IDX_W-1:0] uc_imm,
    input  logic             uc_bank,
    output logic             uc_rvalid,
    output logic [DW-1:0]    uc_rdata,
    output logic             bus_valid,
    input  logic             bus_ready,
    output logic             bus_write,
    output logic             bus_mem,
    output logic [MAW-1:0]   bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata
);

    ap_ctl_t          ctl;
    logic [IDX_W-1:0] idx, reg_addr, new_idx;
    logic [MAW-1:0]   mptr, req_addr;
    logic             busy, rd_done, accept;

    assign uc_ready = !busy;
    assign accept   = uc_valid && uc_ready;
    assign req_addr = ctl.bus_mem ? mptr : MAW'(reg_addr);

    ap_decode #(
        .IDX_W(IDX_W), .DW(DW), .BANK_BIT(BANK_BIT), .PTR_LO_IDX(PTR_LO_IDX)
    ) u_dec (
        .op(ap_op_e'(uc_op)), .wdata(uc_wdata), .offset(uc_offset), .imm(uc_imm),
        .bank(uc_bank), .cur_idx(idx), .ctl(ctl), .reg_addr(reg_addr), .new_idx(new_idx)
    );

    ap_pointer #(
        .IDX_W(IDX_W), .DW(DW), .MEM_STEP(MEM_STEP)
    ) u_ptr (
        .clk(clk), .rst(rst), .accept(accept), .ctl(ctl), .new_idx(new_idx),
        .wdata(uc_wdata), .idx(idx), .mptr(mptr)
    );

    ap_bus_port #(
        .AW(MAW), .DW(DW)
    ) u_bus (
        .clk(clk), .rst(rst), .start(accept && ctl.bus_req), .req_wr(ctl.bus_wr),
        .req_mem(ctl.bus_mem), .req_addr(req_addr), .req_wdata(uc_wdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_mem(bus_mem), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .rd_done(rd_done)
    );

    // Read return: bus completion or local pointer-half read
    always_ff @(posedge clk) begin
        if (rst) begin
            uc_rvalid <= 1'b0;
            uc_rdata  <= '0;
        end else begin
            uc_rvalid <= 1'b0;
            if (rd_done) begin
                uc_rvalid <= 1'b1;
                uc_rdata  <= bus_rdata;
            end else if (accept && is_local_read(ctl)) begin
                uc_rvalid <= 1'b1;
                uc_rdata  <= ctl.rd_lo ? mptr[DW-1:0] : mptr[MAW-1:DW];
            end
        end
    end

endmodule

// File: rtl/ap_regport_chk.sv
module ap_regport_chk #(
    parameter int IDX_W = 16,
    parameter int DW = 32,
    localparam int MAW = 2 * DW
) (
    input logic             clk,
    input logic             rst,
    input logic             uc_valid,
    input logic             uc_ready,
    input logic [1:0]       uc_op,
    input logic [DW-1:0]    uc_wdata,
    input logic [IDX_W-1:0] uc_offset,
    input logic [IDX_W-1:0] uc_imm,
    input logic             uc_bank,
    input logic             uc_rvalid,
    input logic [DW-1:0]    uc_rdata,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic             bus_write,
    input logic             bus_mem,
    input logic [MAW-1:0]   bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata
);

    logic [IDX_W-1:0] cfg_sum;
    assign cfg_sum = uc_offset + uc_imm;

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_valid && uc_ready && !uc_rvalid));

    a_r2_set_no_bus: assert property (@(posedge clk) disable iff (rst)
        (uc_valid && uc_ready && uc_op == 2'd0) |=> (!bus_valid && uc_ready));

    a_r4_read_return: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && !bus_write) |=> (uc_rvalid && uc_rdata == $past(bus_rdata)));

    a_r8_cfg_target: assert property (@(posedge clk) disable iff (rst)
        (uc_valid && uc_ready && uc_op == 2'd3) |=>
        (bus_valid && bus_write && !bus_mem && bus_addr == MAW'($past(cfg_sum))));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=>
        (bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write) && $stable(bus_mem)));

    a_r9_stall: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !uc_ready);

endmodule

bind ap_regport ap_regport_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (.*);

// File: tb/ap_regport_test.sv
`timescale 1ns/1ps
module ap_regport_test;
    import ap_pkg::*;

    localparam logic [15:0] P_LO  = 16'h0530;
    localparam logic [15:0] P_HI  = 16'h0531;
    localparam logic [15:0] P_MEM = 16'h0532;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        uc_valid = 1'b0;
    logic        uc_ready;
    logic [1:0]  uc_op = 2'd0;
    logic [31:0] uc_wdata = '0;
    logic [15:0] uc_offset = '0;
    logic [15:0] uc_imm = '0;
    logic        uc_bank = 1'b0;
    logic        uc_rvalid;
    logic [31:0] uc_rdata;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic        bus_mem;
    logic [63:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    ap_regport uut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // slave model and transaction log
    logic [31:0] store [logic [64:0]];
    int          txn_cnt = 0;
    logic        t_wr, t_mem;
    logic [63:0] t_addr;
    logic [31:0] t_wdata;

    // bench reference state
    logic [15:0] m_idx = '0;
    logic [63:0] m_ptr = '0;

    function automatic logic [31:0] peek(logic [64:0] k);
        return store.exists(k) ? store[k] : (k[31:0] ^ 32'h5A5A_0F0F);
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (bus_ready) bus_ready = 1'b0;
            else if (bus_valid && $urandom_range(0, 2) == 0) begin
                txn_cnt++;
                t_wr = bus_write; t_mem = bus_mem; t_addr = bus_addr; t_wdata = bus_wdata;
                if (bus_write) store[{bus_mem, bus_addr}] = bus_wdata;
                else bus_rdata = peek({bus_mem, bus_addr});
                bus_ready = 1'b1;
            end
        end
    end

    task automatic run_cmd(ap_op_e op, logic [31:0] wd, logic [15:0] off, logic [15:0] imm, logic bank);
        string       rq;
        logic        e_bus = 0, e_wr = 0, e_mem = 0, e_rv = 0;
        logic [63:0] e_addr = '0;
        logic [31:0] e_rd = '0;
        int          c0;
        rq = "R3";
        case (op)
            OP_SET_IDX: begin rq = "R2"; m_idx = wd[15:0] | (bank ? 16'h0800 : 16'h0000); end
            OP_WR_DATA: begin
                if (m_idx == P_LO)      begin rq = "R6"; m_ptr[31:0] = wd;  m_idx++; end
                else if (m_idx == P_HI) begin rq = "R6"; m_ptr[63:32] = wd; m_idx++; end
                else if (m_idx == P_MEM) begin
                    rq = "R7"; e_bus = 1; e_wr = 1; e_mem = 1; e_addr = m_ptr; m_ptr += 64'd4;
                end else begin
                    rq = "R3"; e_bus = 1; e_wr = 1; e_addr = {48'b0, m_idx}; m_idx++;
                end
            end
            OP_RD_ALIAS: begin
                e_rv = 1;
                if (m_idx == P_LO)      begin rq = "R6"; e_rd = m_ptr[31:0];  m_idx++; end
                else if (m_idx == P_HI) begin rq = "R6"; e_rd = m_ptr[63:32]; m_idx++; end
                else if (m_idx == P_MEM) begin
                    rq = "R7"; e_bus = 1; e_mem = 1; e_addr = m_ptr; e_rd = peek({1'b1, m_ptr}); m_ptr += 64'd4;
                end else begin
                    rq = "R4"; e_bus = 1; e_addr = {48'b0, m_idx}; e_rd = peek({17'b0, m_idx}); m_idx++;
                end
            end
            default: begin
                rq = "R8"; e_bus = 1; e_wr = 1; e_addr = {48'b0, 16'(off + imm)};
            end
        endcase
        while (!uc_ready) @(negedge clk);
        c0 = txn_cnt;
        uc_valid = 1'b1; uc_op = op; uc_wdata = wd; uc_offset = off; uc_imm = imm; uc_bank = bank;
        @(negedge clk);
        uc_valid = 1'b0;
        if (e_bus) begin
            check("R9", "valid during access", {63'b0, bus_valid}, 64'd1);
            check("R9", "stall during access", {63'b0, uc_ready}, 64'd0);
        end else begin
            check(rq, "no stall on local op", {63'b0, uc_ready}, 64'd1);
        end
        while (!uc_ready) @(negedge clk);
        check(rq, "bus txn count", 64'(txn_cnt - c0), {63'b0, e_bus});
        if (e_bus) begin
            check(rq, "bus dir", {63'b0, t_wr}, {63'b0, e_wr});
            check(rq, "bus space", {63'b0, t_mem}, {63'b0, e_mem});
            check(rq, "bus addr", t_addr, e_addr);
            if (e_wr) check(rq, "bus wdata", {32'b0, t_wdata}, {32'b0, wd});
        end
        check(rq, "rvalid", {63'b0, uc_rvalid}, {63'b0, e_rv});
        if (e_rv) check(rq, "rdata", {32'b0, uc_rdata}, {32'b0, e_rd});
    endtask

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "uc_ready", {63'b0, uc_ready}, 64'd1);
        check("R1", "bus_valid", {63'b0, bus_valid}, 64'd0);
        check("R1", "uc_rvalid", {63'b0, uc_rvalid}, 64'd0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);              // R1: index 0 after reset
        // R2 + R3: banked index, burst
        run_cmd(OP_SET_IDX, 32'hABCD_0123, 0, 0, 1);
        run_cmd(OP_WR_DATA, 32'h1111_0001, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'h1111_0002, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'h1111_0003, 0, 0, 0);
        run_cmd(OP_SET_IDX, 32'h0000_0923, 0, 0, 1);  // R2: bit already set
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        // R5: wrap
        run_cmd(OP_SET_IDX, 32'h0000_FFFF, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'h5555_AAAA, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'hAAAA_5555, 0, 0, 0);
        run_cmd(OP_SET_IDX, 32'h0000_FFFF, 0, 0, 0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        // R8: config write, index untouched
        run_cmd(OP_SET_IDX, 32'h0000_0200, 0, 0, 0);
        run_cmd(OP_CFG_WR, 32'hC0DE_0001, 16'h0010, 16'h0011, 0);
        run_cmd(OP_CFG_WR, 32'hC0DE_0002, 16'hFFF0, 16'h0020, 0);
        run_cmd(OP_WR_DATA, 32'h0000_0200, 0, 0, 0);
        // R6 + R7: pointer halves, memory window with carry
        run_cmd(OP_SET_IDX, {16'h0, P_LO}, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'hFFFF_FFFC, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'h0000_0001, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'hDEAD_0001, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'hDEAD_0002, 0, 0, 0);
        run_cmd(OP_SET_IDX, {16'h0, P_LO}, 0, 0, 0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        run_cmd(OP_SET_IDX, {16'h0, P_LO}, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'hFFFF_FFFC, 0, 0, 0);
        run_cmd(OP_WR_DATA, 32'h0000_0001, 0, 0, 0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        run_cmd(OP_RD_ALIAS, 0, 0, 0, 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            ap_op_e      op;
            logic [31:0] wd;
            int          sel;
            op  = ap_op_e'($urandom_range(0, 3));
            wd  = $urandom();
            sel = $urandom_range(0, 3);
            if (op == OP_SET_IDX) begin
                if (sel == 0)      wd = {16'h0, P_LO - 16'd2 + 16'($urandom_range(0, 5))};
                else if (sel == 1) wd = {16'h0, 16'hFFFD + 16'($urandom_range(0, 2))};
            end
            run_cmd(op, wd, 16'($urandom()), 16'($urandom()), 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule